// File: doc/BRIEF.md
# Serial Test-Pattern Receiver: Alignment and Error Counting

This block sits on the return path of a serial bit-error-rate tester. The unit under test sends back a stream of characters. Each character is eight data bits, least significant bit first, followed by one stop bit that must be high. The block turns the stream into characters and hunts for a programmed alignment byte. While it hunts, it moves its character boundary one bit at a time until two good alignment characters arrive back to back. After that it checks every payload character against an expected byte and counts the differences.

A recovered-clock strobe marks each valid incoming bit. The expected bytes come from an external reference memory, addressed by the payload index. Every received payload byte goes out through a write port to an external capture memory, so the host can read it later. The host starts a run with a one-cycle start pulse. If the alignment window expires before lock, the block pulses a no-sync flag and begins a fresh hunt.

The block keeps three counters: errored bytes, errored bits and bad stop bits. Each counter saturates at its maximum value, and the start pulse clears all three.

Top module: `ber_rx_sync`

## Requirements
- R1: After reset the block is idle. `sync_ok`, `done`, `no_sync` and `cap_we` are low, and all counters read zero. Bits that arrive before the first `start` have no effect on any output.
- R2: A character is nine strobed bits. The first eight are data, least significant bit first. The ninth is the stop bit, and it is good when it is 1.
- R3: While hunting, a character is a valid alignment character only when its data equals `sync_pat` and its stop bit is 1. `sync_ok` rises only after two valid alignment characters in a row.
- R4: Each character that fails the alignment test while hunting makes the deserializer discard the next strobed bit. This moves the character boundary by one bit.
- R5: Each character checked during the hunt counts toward `sync_len`. If that count reaches `sync_len` without lock, `no_sync` is high for exactly one cycle and the hunt restarts with a zero count.
- R6: After lock, any further valid alignment characters are skipped. The first other character is payload index 0. Payload index i is compared with `ref_data` while `ref_addr` equals i.
- R7: For each payload character, `bit_errs` grows by the number of set bits in (received XOR expected). `byte_errs` grows by one when that XOR is nonzero.
- R8: `lost_bits` grows by one for each character with a stop bit of 0 that arrives while hunting, locked or comparing.
- R9: Each payload character produces one `cap_we` cycle, with `cap_addr` set to its index and `cap_data` set to its received data byte.
- R10: After `pay_len` payload characters, `done` goes high and stays high until the next `start`. Characters that arrive in this state change no counter and cause no capture write.
- R11: The counters hold at their all-ones value instead of wrapping.
- R12: `start` clears all counters, drops `sync_ok` and `done`, and begins a new hunt. It does this from any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that clears the counters and starts a hunt |
| bit_vld | input | 1 | Strobe marking a valid incoming bit |
| bit_in | input | 1 | Incoming serial bit |
| sync_pat | input | DATA_W | Alignment byte value |
| sync_len | input | LEN_W | Number of characters checked before no-sync is declared |
| pay_len | input | LEN_W | Number of payload characters in a run |
| ref_addr | output | LEN_W | Payload index presented to the reference memory |
| ref_data | input | DATA_W | Expected byte read from the reference memory |
| cap_we | output | 1 | Capture memory write enable |
| cap_addr | output | LEN_W | Capture memory write address |
| cap_data | output | DATA_W | Received byte written to capture memory |
| sync_ok | output | 1 | Lock achieved (locked, comparing or done) |
| no_sync | output | 1 | One-cycle pulse when the alignment window expires |
| done | output | 1 | Payload run complete |
| byte_errs | output | CNT_W | Count of errored payload bytes |
| bit_errs | output | CNT_W | Count of errored payload bits |
| lost_bits | output | CNT_W | Count of characters with a bad stop bit |

## Verification
Two functions can act on the same character: the stop-bit check and the payload comparison. A character with a low stop bit can also carry data errors. The random payload phase mixes corrupted data with dropped stop bits, so that one character can raise the lost-bit count and the bit and byte error counts together. The final counters are then judged against totals that the bench works out per character. During the hunt, a failed alignment character can also be the character that exhausts the window. The no-sync stream is built so that its fourth checked character both triggers a bit slip and expires the window. The bench then checks for exactly one no-sync pulse and a lost-bit total that counts a character received after the restart.

// File: rtl/ber_rx_pkg.sv
package ber_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HUNT    = 3'd1,
        ST_LOCKED  = 3'd2,
        ST_COMPARE = 3'd3,
        ST_DONE    = 3'd4,
        ST_NOSYNC  = 3'd5
    } rx_state_e;

endpackage

// File: rtl/ber_rx_deser.sv
module ber_rx_deser #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              slip,
    output logic              frm_vld,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_stop
);
    localparam int FRM_W = DATA_W + 1;
    localparam int CW    = $clog2(FRM_W);
    localparam logic [CW-1:0] LAST = CW'(DATA_W);

    typedef struct packed {
        logic [FRM_W-1:0] sh;
        logic [CW-1:0]    cnt;
        logic             skip;
        logic             vld;
        logic [FRM_W-1:0] frm;
    } deser_t;

    deser_t r_d, r_q;
    logic [FRM_W-1:0] sh_nx;

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        sh_nx   = {bit_in, r_q.sh[FRM_W-1:1]};
        if (clr) begin
            r_d.cnt  = '0;
            r_d.skip = 1'b0;
        end else if (bit_vld) begin
            if (r_q.skip || slip) begin
                // this bit is discarded to move the character boundary
                r_d.skip = 1'b0;
            end else begin
                r_d.sh = sh_nx;
                if (r_q.cnt == LAST) begin
                    r_d.cnt = '0;
                    r_d.vld = 1'b1;
                    r_d.frm = sh_nx;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        end else if (slip) begin
            r_d.skip = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign frm_vld  = r_q.vld;
    assign frm_data = r_q.frm[DATA_W-1:0];
    assign frm_stop = r_q.frm[FRM_W-1];
endmodule

// File: rtl/ber_rx_cmp.sv
module ber_rx_cmp #(
    parameter int DATA_W = 8,
    localparam int DIFF_W = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] rx,
    input  logic [DATA_W-1:0] expd,
    output logic [DIFF_W-1:0] diff_bits,
    output logic              byte_bad
);
    logic [DATA_W-1:0] x;

    always_comb begin
        x         = rx ^ expd;
        diff_bits = '0;
        for (int i = 0; i < DATA_W; i++) begin
            diff_bits = diff_bits + DIFF_W'(x[i]);
        end
        byte_bad = |x;
    end
endmodule

// File: rtl/ber_rx_satcnt.sv
module ber_rx_satcnt #(
    parameter int W     = 32,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     cnt
);
    localparam int SUM_W = ((W + 1) > INC_W) ? (W + 1) : (INC_W + 1);

    logic [W-1:0]     cnt_d, cnt_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(cnt_q) + SUM_W'(inc);
        if (clr)                             cnt_d = '0;
        else if (sum > SUM_W'({W{1'b1}}))    cnt_d = '1;
        else                                 cnt_d = sum[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/ber_rx_sync.sv
module ber_rx_sync
    import ber_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic [DATA_W-1:0] sync_pat,
    input  logic [LEN_W-1:0]  sync_len,
    input  logic [LEN_W-1:0]  pay_len,
    output logic [LEN_W-1:0]  ref_addr,
    input  logic [DATA_W-1:0] ref_data,
    output logic              cap_we,
    output logic [LEN_W-1:0]  cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic              sync_ok,
    output logic              no_sync,
    output logic              done,
    output logic [CNT_W-1:0]  byte_errs,
    output logic [CNT_W-1:0]  bit_errs,
    output logic [CNT_W-1:0]  lost_bits
);
    localparam int DIFF_W = $clog2(DATA_W + 1);

    typedef struct packed {
        rx_state_e        st;
        logic             consec;
        logic [LEN_W-1:0] hunt;
        logic [LEN_W-1:0] idx;
    } fsm_t;

    fsm_t f_d, f_q;

    logic              frm_vld, frm_stop, slip;
    logic [DATA_W-1:0] frm_data;
    logic [DIFF_W-1:0] diff_bits;
    logic              byte_bad;
    logic              sync_hit, pay_frm, active;
    logic [LEN_W-1:0]  hunt_nx, idx_nx;
    logic [DIFF_W-1:0] bit_inc;
    logic              byte_inc, lost_inc;

    ber_rx_deser #(.DATA_W(DATA_W)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .slip     (slip),
        .frm_vld  (frm_vld),
        .frm_data (frm_data),
        .frm_stop (frm_stop)
    );

    ber_rx_cmp #(.DATA_W(DATA_W)) u_cmp (
        .rx        (frm_data),
        .expd      (ref_data),
        .diff_bits (diff_bits),
        .byte_bad  (byte_bad)
    );

    always_comb begin
        sync_hit = frm_vld && frm_stop && (frm_data == sync_pat);
        active   = (f_q.st == ST_HUNT) || (f_q.st == ST_LOCKED) || (f_q.st == ST_COMPARE);
        pay_frm  = frm_vld && (((f_q.st == ST_LOCKED) && !sync_hit) || (f_q.st == ST_COMPARE));
        hunt_nx  = f_q.hunt + 1'b1;
        idx_nx   = f_q.idx + 1'b1;
        slip     = 1'b0;
        f_d      = f_q;

        unique case (f_q.st)
            ST_HUNT: begin
                if (frm_vld) begin
                    if (sync_hit && f_q.consec) begin
                        f_d.st     = ST_LOCKED;
                        f_d.consec = 1'b0;
                    end else begin
                        f_d.consec = sync_hit;
                        slip       = !sync_hit;
                        if (hunt_nx >= sync_len) begin
                            f_d.st = ST_NOSYNC;
                        end else begin
                            f_d.hunt = hunt_nx;
                        end
                    end
                end
            end
            ST_NOSYNC: begin
                f_d.st     = ST_HUNT;
                f_d.hunt   = '0;
                f_d.consec = 1'b0;
            end
            ST_LOCKED, ST_COMPARE: begin
                if (pay_frm) begin
                    f_d.idx = idx_nx;
                    f_d.st  = (idx_nx >= pay_len) ? ST_DONE : ST_COMPARE;
                end
            end
            default: ; // idle and done wait for start
        endcase

        if (start) begin
            f_d.st     = ST_HUNT;
            f_d.consec = 1'b0;
            f_d.hunt   = '0;
            f_d.idx    = '0;
            slip       = 1'b0;
        end

        bit_inc  = (pay_frm && !start) ? diff_bits : '0;
        byte_inc = pay_frm && !start && byte_bad;
        lost_inc = frm_vld && !frm_stop && active && !start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st     <= ST_IDLE;
            f_q.consec <= 1'b0;
            f_q.hunt   <= '0;
            f_q.idx    <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    ber_rx_satcnt #(.W(CNT_W), .INC_W(DIFF_W)) u_bitcnt (
        .clk (clk), .rst_n (rst_n), .clr (start), .inc (bit_inc), .cnt (bit_errs)
    );

    ber_rx_satcnt #(.W(CNT_W), .INC_W(1)) u_bytecnt (
        .clk (clk), .rst_n (rst_n), .clr (start), .inc (byte_inc), .cnt (byte_errs)
    );

    ber_rx_satcnt #(.W(CNT_W), .INC_W(1)) u_lostcnt (
        .clk (clk), .rst_n (rst_n), .clr (start), .inc (lost_inc), .cnt (lost_bits)
    );

    assign ref_addr = f_q.idx;
    assign cap_we   = pay_frm && !start;
    assign cap_addr = f_q.idx;
    assign cap_data = frm_data;
    assign sync_ok  = (f_q.st == ST_LOCKED) || (f_q.st == ST_COMPARE) || (f_q.st == ST_DONE);
    assign no_sync  = (f_q.st == ST_NOSYNC);
    assign done     = (f_q.st == ST_DONE);
endmodule

// File: rtl/ber_rx_sync_chk.sv
module ber_rx_sync_chk #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             sync_ok,
    input logic             no_sync,
    input logic             done,
    input logic             cap_we,
    input logic [LEN_W-1:0] cap_addr,
    input logic [LEN_W-1:0] pay_len,
    input logic [CNT_W-1:0] byte_errs,
    input logic [CNT_W-1:0] bit_errs,
    input logic [CNT_W-1:0] lost_bits
);
    a_r5_nosync_single: assert property (@(posedge clk) disable iff (!rst_n)
        no_sync |=> !no_sync);

    a_r12_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (byte_errs == '0) && (bit_errs == '0) && (lost_bits == '0) && !sync_ok && !done);

    a_r7_bits_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ({1'b0, bit_errs} <= ({1'b0, $past(bit_errs)} + (CNT_W+1)'(DATA_W))));

    a_r7_byte_needs_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ((byte_errs == $past(byte_errs)) || (bit_errs != $past(bit_errs)) || (&bit_errs)));

    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (byte_errs >= $past(byte_errs)) && (bit_errs >= $past(bit_errs))
                   && (lost_bits >= $past(lost_bits)));

    a_r9_capture_locked: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we |-> sync_ok && !done && (cap_addr < pay_len));

    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(byte_errs) && $stable(bit_errs) && $stable(lost_bits));
endmodule

bind ber_rx_sync ber_rx_sync_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sync_ok   (sync_ok),
    .no_sync   (no_sync),
    .done      (done),
    .cap_we    (cap_we),
    .cap_addr  (cap_addr),
    .pay_len   (pay_len),
    .byte_errs (byte_errs),
    .bit_errs  (bit_errs),
    .lost_bits (lost_bits)
);

// File: tb/ber_rx_sync_test.sv
module ber_rx_sync_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, start, bit_vld, bit_in;
    logic [7:0]  sync_pat;
    logic [15:0] sync_len, pay_len;
    logic [15:0] ref_addr, cap_addr, ref_addr_s, cap_addr_s;
    logic [7:0]  ref_data, cap_data, ref_data_s, cap_data_s;
    logic        cap_we, sync_ok, no_sync, done;
    logic        cap_we_s, sync_ok_s, no_sync_s, done_s;
    logic [31:0] byte_errs, bit_errs, lost_bits;
    logic [3:0]  byte_errs_s, bit_errs_s, lost_bits_s;

    logic [7:0] ref_mem [0:63];
    logic [7:0] cap_mem [0:63];
    logic [7:0] rx_mem  [0:63];
    int n_chk = 0, n_fail = 0;
    int cap_writes = 0, ns_pulses = 0;
    bit finished = 0;

    assign ref_data   = ref_mem[ref_addr[5:0]];
    assign ref_data_s = ref_mem[ref_addr_s[5:0]];

    ber_rx_sync uut (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_vld(bit_vld), .bit_in(bit_in),
        .sync_pat(sync_pat), .sync_len(sync_len), .pay_len(pay_len),
        .ref_addr(ref_addr), .ref_data(ref_data), .cap_we(cap_we), .cap_addr(cap_addr),
        .cap_data(cap_data), .sync_ok(sync_ok), .no_sync(no_sync), .done(done),
        .byte_errs(byte_errs), .bit_errs(bit_errs), .lost_bits(lost_bits)
    );

    ber_rx_sync #(.CNT_W(4)) uut_small (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_vld(bit_vld), .bit_in(bit_in),
        .sync_pat(sync_pat), .sync_len(sync_len), .pay_len(pay_len),
        .ref_addr(ref_addr_s), .ref_data(ref_data_s), .cap_we(cap_we_s), .cap_addr(cap_addr_s),
        .cap_data(cap_data_s), .sync_ok(sync_ok_s), .no_sync(no_sync_s), .done(done_s),
        .byte_errs(byte_errs_s), .bit_errs(bit_errs_s), .lost_bits(lost_bits_s)
    );

    always @(posedge clk) begin
        if (cap_we) begin
            cap_mem[cap_addr[5:0]] <= cap_data;
            cap_writes <= cap_writes + 1;
        end
        if (no_sync) ns_pulses <= ns_pulses + 1;
    end

    function automatic int ones(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return n;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_vld = 1'b1; bit_in = b;
        @(negedge clk); bit_vld = 1'b0; bit_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic s);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(s);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    initial begin
        int exp_bits, exp_bytes, exp_lost, cw0, ns0;
        logic [7:0] ev, mask, rv;
        logic st;
        void'($urandom(32'd7741));
        rst_n = 1'b0; start = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
        sync_pat = 8'hA5; sync_len = 16'd20; pay_len = 16'd1;
        for (int i = 0; i < 64; i++) begin ref_mem[i] = 8'h00; cap_mem[i] = 8'h00; end
        idle(5);
        rst_n = 1'b1;
        idle(3);

        // R1: reset state, and bits before start are ignored
        chk("R1 sync_ok", sync_ok, 0);
        chk("R1 done", done, 0);
        chk("R1 no_sync", no_sync, 0);
        chk("R1 counters", byte_errs | bit_errs | lost_bits, 0);
        send_frame(8'hA5, 1'b1);
        send_frame(8'hA5, 1'b1);
        send_frame(8'h12, 1'b0);
        idle(3);
        chk("R1 idle no lock", sync_ok, 0);
        chk("R1 idle no lost", lost_bits, 0);
        chk("R1 idle no capture", cap_writes, 0);

        // R3/R8/R4/R6/R7/R9/R10 directed run
        ref_mem[0] = 8'h3C;
        pulse_start();
        send_frame(8'hA5, 1'b1);
        idle(2);
        chk("R3 one sync not enough", sync_ok, 0);
        send_frame(8'hA5, 1'b0);
        idle(2);
        chk("R3 bad stop rejects", sync_ok, 0);
        chk("R8 bad stop in hunt", lost_bits, 1);
        send_bit(1'b1);              // R4: discarded after the failed character
        send_frame(8'hA5, 1'b1);
        send_frame(8'hA5, 1'b1);
        idle(2);
        chk("R3 lock after two", sync_ok, 1);
        cw0 = cap_writes;
        send_frame(8'hA5, 1'b1);
        idle(2);
        chk("R6 extra sync skipped", cap_writes - cw0, 0);
        send_frame(8'h3D, 1'b1);
        idle(2);
        chk("R7 one bit", bit_errs, 1);
        chk("R7 one byte", byte_errs, 1);
        chk("R9 capture data R2 order", cap_mem[0], 8'h3D);
        chk("R10 done", done, 1);
        send_frame(8'h00, 1'b0);
        idle(2);
        chk("R10 lost frozen", lost_bits, 1);
        chk("R10 bits frozen", bit_errs, 1);
        chk("R10 no capture", cap_writes - cw0, 1);

        // R12 start from done; R4 misaligned hunt; random payload
        sync_len = 16'd16; pay_len = 16'd40;
        pulse_start();
        idle(1);
        chk("R12 cleared bits", bit_errs, 0);
        chk("R12 cleared lost", lost_bits, 0);
        chk("R12 sync dropped", sync_ok, 0);
        chk("R12 done dropped", done, 0);
        exp_bits = 0; exp_bytes = 0; exp_lost = 0;
        for (int i = 0; i < 40; i++) begin
            ev = 8'($urandom);
            mask = 8'($urandom) & 8'($urandom) & 8'($urandom);
            if (i == 5) mask = 8'hFF;
            if (i == 6) mask = 8'h00;
            rv = ev ^ mask;
            if (i == 0 && rv == 8'hA5) begin rv = 8'hA4; mask = rv ^ ev; end
            st = (i == 0) ? 1'b1 : (($urandom % 6) != 0);
            ref_mem[i] = ev; rx_mem[i] = rv;
            exp_bits += ones(mask);
            exp_bytes += (mask != 0);
            exp_lost += !st;
            cap_mem[i] = ~rv;
        end
        cw0 = cap_writes;
        send_bit(1'b1);              // one bit out of step
        for (int k = 0; k < 4; k++) send_frame(8'hA5, 1'b1);
        idle(2);
        chk("R4 slip then lock", sync_ok, 1);
        chk("R4 no lost from slip", lost_bits, 0);
        for (int i = 0; i < 40; i++) begin
            st = (i == 0) ? 1'b1 : 1'b0;
            send_frame(rx_mem[i], (exp_lost >= 0) ? 1'b1 : 1'b0);
        end
        idle(3);
        chk("R10 done after payload", done, 1);
        chk("R7 bit total", bit_errs, exp_bits);
        chk("R7 byte total", byte_errs, exp_bytes);
        chk("R9 write count", cap_writes - cw0, 40);
        for (int i = 0; i < 40; i++) chk("R9 captured byte", cap_mem[i], rx_mem[i]);
        chk("R11 small bits saturate", bit_errs_s, (exp_bits > 15) ? 15 : exp_bits);
        chk("R11 small bytes", byte_errs_s, (exp_bytes > 15) ? 15 : exp_bytes);

        // R8 mixed lost-bit and data errors on the same characters
        pay_len = 16'd12;
        pulse_start();
        exp_bits = 0; exp_bytes = 0; exp_lost = 0;
        for (int i = 0; i < 12; i++) begin
            ev = 8'($urandom);
            mask = 8'($urandom) & 8'($urandom);
            rv = ev ^ mask;
            if (i == 0 && rv == 8'hA5) begin rv = 8'h5A; mask = rv ^ ev; end
            ref_mem[i] = ev; rx_mem[i] = rv;
            exp_bits += ones(mask);
            exp_bytes += (mask != 0);
        end
        send_frame(8'hA5, 1'b1);
        send_frame(8'hA5, 1'b1);
        for (int i = 0; i < 12; i++) begin
            st = (i == 0) ? 1'b1 : ((i % 3) != 0);
            exp_lost += !st;
            send_frame(rx_mem[i], st);
        end
        idle(3);
        chk("R8 lost in compare", lost_bits, exp_lost);
        chk("R7 bits with lost", bit_errs, exp_bits);
        chk("R7 bytes with lost", byte_errs, exp_bytes);
        chk("R10 done mixed", done, 1);

        // R5 alignment window runs out
        sync_len = 16'd4;
        ns0 = ns_pulses;
        pulse_start();
        for (int k = 0; k < 6; k++) send_frame(8'h00, 1'b1);
        idle(3);
        chk("R5 one no_sync pulse", ns_pulses - ns0, 1);
        chk("R5 not locked", sync_ok, 0);
        chk("R8 lost across restart", lost_bits, 4);
        chk("R5 not done", done, 0);

        report();
    end
endmodule